// File: doc/BRIEF.md
# Bitplane to Raster Pixel Unpacker

This block sits between the graphics memory read path and the palette of one sprite or display layer. Each pixel clock it receives the byte that the address generator has fetched and a command byte carrying a window flag and the low three bits of the bit-granular read pointer. From these it produces one 8-bit palette index and a flag saying whether a pixel is present at this position.

The two low bits of a mode byte set the colour depth. In 1-bit and 2-bit depths the raw pixel bits are not sent straight to the palette. A 1-bit pixel chooses between a background and a foreground colour byte. At 2-bit and 4-bit depth, the high bits of the background colour byte become the palette base, so a layer can be moved to any group of 4 or 16 entries. At 8-bit depth the byte is used as the index unchanged. The sub-pixel position picks which bit group inside the byte forms the current pixel. Groups are numbered from the most significant end, so the group that is displayed first sits in the top bits.

The output is registered. It advances only on cycles where the pixel-clock enable is high and holds its value on every other cycle.

Top module: `bitplane_pixel_unpacker`

## Requirements
- R1: While rst_n is low, pix_index is 0 and pix_valid is 0.
- R2: With depth_mode[1:0] = 0 (1 bit per pixel), the pixel is bit (7 - s) of ram_byte, where s = pix_cmd[2:0]. A 0 gives bg_colour and a 1 gives fg_colour.
- R3: With depth_mode[1:0] = 1 (2 bits per pixel), the pixel value is ram_byte[7-2k : 6-2k], where k = s[2:1]. The index is {bg_colour[7:2], value}.
- R4: With depth_mode[1:0] = 2 (4 bits per pixel), the pixel value is ram_byte[7:4] when s[2] = 0 and ram_byte[3:0] when s[2] = 1. The index is {bg_colour[7:4], value}.
- R5: With depth_mode[1:0] = 3 (8 bits per pixel), the index is ram_byte, whatever s is.
- R6: pix_valid follows pix_cmd[7] (1 = inside the window). When pix_cmd[7] is 0, pix_valid is 0 and pix_index is 0.
- R7: pix_cmd[6] (the two-byte pixel request) has no effect on pix_index or pix_valid.
- R8: On a rising clock edge with pix_en high, the outputs take the value computed from the inputs present at that edge. The result therefore appears one clock after the inputs are applied.
- R9: On a rising clock edge with pix_en low, pix_index and pix_valid keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; the block advances only when high |
| ram_byte | input | 8 | Data byte fetched from video memory |
| pix_cmd | input | 8 | Bit 7 window flag, bit 6 two-byte request (ignored), bits 2:0 sub-pixel position |
| depth_mode | input | 8 | Bits 1:0 select colour depth; other bits unused |
| bg_colour | input | 8 | Background colour / palette base |
| fg_colour | input | 8 | Foreground colour for 1-bit depth |
| pix_index | output | 8 | Registered palette index |
| pix_valid | output | 1 | Registered pixel-present flag |

## Verification
Every internal value reaches a port one clock later, because nothing sits between the combinational mapping and the output register. A wrong group selection or base merge therefore shows up as a wrong pix_index on the first enabled edge. This can be a swapped nibble or a reversed 2-bit order, so each sub-position is driven against a known byte at every depth. A wrongly kept or dropped window flag or enable shows up as pix_valid or a held value out of step with the inputs. The bench checks for this on every cycle, including long stretches with the enable low.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int BYTE_W  = 8;
  localparam int SUB_W   = $clog2(BYTE_W);
  localparam int DEPTHS  = SUB_W + 1;
  localparam int DEPTH_W = $clog2(DEPTHS);
  localparam int WIN_BIT  = 7;
  localparam int WIDE_BIT = 6;

  typedef enum logic [DEPTH_W-1:0] {
    DEPTH_1 = 2'd0,
    DEPTH_2 = 2'd1,
    DEPTH_4 = 2'd2,
    DEPTH_8 = 2'd3
  } depth_e;

  // Mask of the low (1 << d) bits of a byte.
  function automatic logic [BYTE_W-1:0] group_mask(input int d);
    int w;
    w = 1 << d;
    return ~({BYTE_W{1'b1}} << w);
  endfunction

  // Right shift that moves the addressed group to bit 0; group 0 is at the MSB end.
  function automatic int group_shift(input int d, input logic [SUB_W-1:0] sub);
    int w;
    int slot;
    w    = 1 << d;
    slot = int'(sub) >> d;
    return BYTE_W - w - slot * w;
  endfunction

  // Merge a pixel group under the high bits of the base colour.
  function automatic logic [BYTE_W-1:0] merge_base(input logic [BYTE_W-1:0] base,
                                                   input logic [BYTE_W-1:0] grp,
                                                   input int d);
    return (base & ~group_mask(d)) | (grp & group_mask(d));
  endfunction
endpackage

// File: rtl/bpu_group_select.sv
module bpu_group_select
  import bpu_pkg::*;
(
  input  logic [BYTE_W-1:0]  data,
  input  logic [SUB_W-1:0]   sub,
  input  logic [DEPTH_W-1:0] depth,
  output logic [BYTE_W-1:0]  grp
);
  logic [BYTE_W-1:0] cand [DEPTHS];

  // One extractor per colour depth; the mode picks one afterwards.
  for (genvar g = 0; g < DEPTHS; g++) begin : g_depth
    assign cand[g] = (data >> group_shift(g, sub)) & group_mask(g);
  end

  assign grp = cand[depth];
endmodule

// File: rtl/bpu_colour_map.sv
module bpu_colour_map
  import bpu_pkg::*;
(
  input  logic [BYTE_W-1:0]  grp,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [BYTE_W-1:0]  bg,
  input  logic [BYTE_W-1:0]  fg,
  output logic [BYTE_W-1:0]  mapped
);
  always_comb begin
    if (depth == DEPTH_1) begin
      mapped = grp[0] ? fg : bg;
    end else begin
      mapped = merge_base(bg, grp, int'(depth));
    end
  end
endmodule

// File: rtl/bpu_out_stage.sv
module bpu_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] in_index,
  input  logic         in_valid,
  output logic [W-1:0] out_index,
  output logic         out_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_index <= '0;
      out_valid <= 1'b0;
    end else if (en) begin
      out_index <= in_index;
      out_valid <= in_valid;
    end
  end
endmodule

// File: rtl/bitplane_pixel_unpacker.sv
module bitplane_pixel_unpacker
  import bpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [BYTE_W-1:0] ram_byte,
  input  logic [BYTE_W-1:0] pix_cmd,
  input  logic [BYTE_W-1:0] depth_mode,
  input  logic [BYTE_W-1:0] bg_colour,
  input  logic [BYTE_W-1:0] fg_colour,
  output logic [BYTE_W-1:0] pix_index,
  output logic              pix_valid
);
  // Named internal events, visible to the bound checker.
  logic [DEPTH_W-1:0] depth_sel;
  logic [SUB_W-1:0]   sub_pos;
  logic               in_window;
  logic [BYTE_W-1:0]  grp_bits;
  logic [BYTE_W-1:0]  mapped_index;
  logic [BYTE_W-1:0]  next_index;
  logic               next_valid;

  assign depth_sel = depth_mode[DEPTH_W-1:0];
  assign sub_pos   = pix_cmd[SUB_W-1:0];
  assign in_window = pix_cmd[WIN_BIT];

  // The two-byte pixel request and the spare bits are accepted and dropped.
  logic unused_bits;
  assign unused_bits = ^{pix_cmd[WIDE_BIT], pix_cmd[WIDE_BIT-1:SUB_W],
                         depth_mode[BYTE_W-1:DEPTH_W]};

  bpu_group_select u_sel (
    .data  (ram_byte),
    .sub   (sub_pos),
    .depth (depth_sel),
    .grp   (grp_bits)
  );

  bpu_colour_map u_map (
    .grp    (grp_bits),
    .depth  (depth_sel),
    .bg     (bg_colour),
    .fg     (fg_colour),
    .mapped (mapped_index)
  );

  assign next_valid = in_window;
  assign next_index = in_window ? mapped_index : '0;

  bpu_out_stage #(.W(BYTE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (pix_en),
    .in_index  (next_index),
    .in_valid  (next_valid),
    .out_index (pix_index),
    .out_valid (pix_valid)
  );
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pix_en,
  input logic [7:0] ram_byte,
  input logic [7:0] pix_cmd,
  input logic [7:0] depth_mode,
  input logic [7:0] bg_colour,
  input logic [7:0] fg_colour,
  input logic [7:0] pix_index,
  input logic       pix_valid,
  input logic [7:0] next_index
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !$past(pix_en) |-> $stable(pix_index) && $stable(pix_valid)); // R9

  AST_STAGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(pix_en) |-> pix_index == $past(next_index)); // R8

  AST_VALID_FOLLOWS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(pix_en) |-> pix_valid == $past(pix_cmd[7])); // R6

  AST_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix_index == 8'h00); // R6

  AST_ONE_BIT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(pix_en && pix_cmd[7] && depth_mode[1:0] == 2'd0)
    |-> pix_index == $past(bg_colour) || pix_index == $past(fg_colour)); // R2

  AST_FOUR_COLOUR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(pix_en && pix_cmd[7] && depth_mode[1:0] == 2'd1)
    |-> pix_index[7:2] == $past(bg_colour[7:2])); // R3

  AST_SIXTEEN_COLOUR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(pix_en && pix_cmd[7] && depth_mode[1:0] == 2'd2)
    |-> pix_index[7:4] == $past(bg_colour[7:4])); // R4

  AST_DIRECT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(pix_en && pix_cmd[7] && depth_mode[1:0] == 2'd3)
    |-> pix_index == $past(ram_byte)); // R5
endmodule

bind bitplane_pixel_unpacker bpu_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_en     (pix_en),
  .ram_byte   (ram_byte),
  .pix_cmd    (pix_cmd),
  .depth_mode (depth_mode),
  .bg_colour  (bg_colour),
  .fg_colour  (fg_colour),
  .pix_index  (pix_index),
  .pix_valid  (pix_valid),
  .next_index (next_index)
);

// File: tb/bitplane_pixel_unpacker_test.sv
`timescale 1ns/1ps
module bitplane_pixel_unpacker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0;
  logic [7:0] ram_byte = 8'h00;
  logic [7:0] pix_cmd = 8'h00;
  logic [7:0] depth_mode = 8'h00;
  logic [7:0] bg_colour = 8'h00;
  logic [7:0] fg_colour = 8'h00;
  logic [7:0] pix_index;
  logic       pix_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int    exp_idx = 0;
  int    exp_val = 0;
  string exp_tag = "R1";

  always #5 clk = ~clk;

  bitplane_pixel_unpacker uut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .ram_byte(ram_byte),
    .pix_cmd(pix_cmd), .depth_mode(depth_mode), .bg_colour(bg_colour),
    .fg_colour(fg_colour), .pix_index(pix_index), .pix_valid(pix_valid)
  );

  // Behavioural palette-index model, written from the requirements.
  function automatic int model_index(int b, int md, int c, int bg, int fg);
    int s;
    int v;
    s = c % 8;
    if ((c / 128) % 2 == 0) return 0;              // R6 outside window
    case (md % 4)
      0: begin v = (b >> (7 - s)) % 2; return (v == 1) ? fg : bg; end   // R2
      1: begin v = (b >> (6 - 2 * (s / 2))) % 4; return (bg / 4) * 4 + v; end // R3
      2: begin v = (s < 4) ? (b / 16) : (b % 16); return (bg / 16) * 16 + v; end // R4
      default: return b;                          // R5
    endcase
  endfunction

  function automatic string tag_for(int md, int c);
    if ((c / 128) % 2 == 0) return "R6/R8";
    if ((c / 64) % 2 == 1) return "R7/R8";
    case (md % 4)
      0: return "R2/R8";
      1: return "R3/R8";
      2: return "R4/R8";
      default: return "R5/R8";
    endcase
  endfunction

  // Reference updates at the same edge as the design; inputs change only at negedges.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_idx = 0; exp_val = 0; exp_tag = "R1";
    end else if (pix_en) begin
      exp_idx = model_index(ram_byte, depth_mode, pix_cmd, bg_colour, fg_colour);
      exp_val = pix_cmd[7];
      exp_tag = tag_for(depth_mode, pix_cmd);
    end else begin
      exp_tag = "R9";
    end
  end

  task automatic compare();
    checks++;
    if (int'(pix_index) != exp_idx || int'(pix_valid) != exp_val) begin
      fails++;
      $display("FAIL %s: index=%0h valid=%0d expected index=%0h valid=%0d",
               exp_tag, pix_index, pix_valid, exp_idx, exp_val);
    end
  endtask

  task automatic step(input logic en, input logic [7:0] b, input logic [7:0] c,
                      input logic [7:0] md, input logic [7:0] bg, input logic [7:0] fg);
    @(negedge clk);
    compare();
    pix_en = en; ram_byte = b; pix_cmd = c; depth_mode = md;
    bg_colour = bg; fg_colour = fg;
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 8'hFF, 8'hFF, 8'h03, 8'h55, 8'hAA);
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R2: 1-bit depth, MSB first
    for (int s = 0; s < 8; s++) step(1'b1, 8'hA5, 8'(8'h80 | s), 8'h00, 8'h12, 8'h34);
    // R3: 2-bit depth
    for (int s = 0; s < 8; s++) step(1'b1, 8'h1B, 8'(8'h80 | s), 8'h01, 8'hC9, 8'h00);
    // R4: 4-bit depth, high nibble first
    for (int s = 0; s < 8; s++) step(1'b1, 8'h3C, 8'(8'h80 | s), 8'h02, 8'h7E, 8'h00);
    // R5: 8-bit depth ignores sub-position
    for (int s = 0; s < 8; s++) step(1'b1, 8'(8'h91 + s), 8'(8'h80 | s), 8'h03, 8'h44, 8'h00);
    // R6: outside window
    for (int md = 0; md < 4; md++) step(1'b1, 8'hFF, 8'h07, 8'(md), 8'hFF, 8'hFF);
    // R7: two-byte request bit set
    for (int md = 0; md < 4; md++) step(1'b1, 8'h6D, 8'hC5, 8'(md), 8'hB3, 8'h2E);
    // R9: enable low holds
    step(1'b1, 8'h5A, 8'h80, 8'h03, 8'h00, 8'h00);
    for (int i = 0; i < 6; i++) step(1'b0, 8'(i * 37), 8'h03, 8'h00, 8'h11, 8'h22);
    // Mixed random traffic covering all requirements
    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, 8'($urandom), 8'($urandom), 8'($urandom),
           8'($urandom), 8'($urandom));
    // Reset in the middle of traffic: R1
    step(1'b1, 8'hEE, 8'h83, 8'h03, 8'h00, 8'h00);
    rst_n = 1'b0;
    step(1'b1, 8'hEE, 8'h83, 8'h03, 8'h00, 8'h00);
    step(1'b1, 8'hEE, 8'h83, 8'h03, 8'h00, 8'h00);
    rst_n = 1'b1;
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    step(1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule